// File: doc/BRIEF.md
# LCD controller register file

This block is the software-visible register bank of a colour LCD controller. It sits on a simple 32-bit bus with a 4 KB window of word-aligned offsets. It stores four panel timing words, two frame base addresses (one per panel half), an interrupt enable mask and a control word. It also keeps a set of sticky interrupt status bits, and software clears them by writing ones.

For downstream pixel logic, the block derives the panel width and height from the timing words and decodes the control word into a colour-depth code, channel and byte-order selects, and a single "display on" flag. Writes that land in the palette window are forwarded through a one-cycle write port, because palette storage is outside this block. A read-only window at the top of the space returns eight fixed identification bytes. Read data and the error flag both appear one cycle after the access. Any access the map does not accept returns zero, raises the error flag and changes nothing.

Top module: `lcdc_regfile`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads zero. Columns, rows, colour mode, order flags, `disp_on`, `resize_pulse` and `pal_we` are all zero.
- R2: Word indices 0 to 7 (offset divided by 4) are read/write: four timing words, the upper base, the lower base, the mask and the control word. A read returns the stored value on `bus_rdata` in the cycle after the access.
- R3: A write to index 0 sets `panel_cols` to ((value AND 0xFC) + 4) * 4 in the following cycle.
- R4: A write to index 1 sets `panel_rows` to (value AND 0x3FF) + 1 in the following cycle.
- R5: In the control word, bit 0 is enable and bit 11 is power, and `disp_on` is high only when both are set. Bits 3:1 drive `pix_mode`, bit 8 drives `swap_rb`, bit 9 drives `byte_be` and bit 10 drives `pixel_be`.
- R6: A high bit on `irq_set` sets the matching status bit, and the bit stays set. Index 8 reads the raw status and index 9 reads the status AND the mask. The mask keeps only its low IRQ_W bits.
- R7: A write to index 10 clears each status bit written as 1. A set pulse arriving in the same cycle wins over the clear.
- R8: Index 11 reads the upper base address and index 12 reads the lower base address.
- R9: A write to offsets 0x200 to 0x3FC pulses `pal_we` for one cycle in the next cycle, with `pal_idx` = (offset - 0x200)/4 and `pal_wdata` = the written value. Reads of this window return zero with no error.
- R10: Reads of offsets 0xFE0 to 0xFFC return one byte per word, in ascending order: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: An access outside the accepted map reads zero and pulses `bus_err` in the cycle after, and leaves all state unchanged. This covers any access to an unmapped offset, a write to index 8, 9, 11 or 12, a write to the identification window, and a read of index 10.
- R12: `resize_pulse` is high for exactly one cycle, together with the new size, when a timing write changes the columns or rows while `disp_on` is high. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the access |
| bus_err | output | 1 | Rejected access, one cycle after the access |
| irq_set | input | IRQ_W | Interrupt source set pulses |
| pal_we | output | 1 | Palette write strobe |
| pal_idx | output | PAL_IDX_W | Palette entry index |
| pal_wdata | output | DATA_W | Palette write data |
| panel_cols | output | COL_W | Derived panel width |
| panel_rows | output | ROW_W | Derived panel height |
| pix_mode | output | 3 | Bits-per-pixel code |
| disp_on | output | 1 | Enable and power both set |
| swap_rb | output | 1 | Blue-green-red channel order |
| byte_be | output | 1 | Big-endian byte order |
| pixel_be | output | 1 | Big-endian pixel order |
| upper_base | output | DATA_W | Upper panel frame base |
| lower_base | output | DATA_W | Lower panel frame base |
| resize_pulse | output | 1 | Size changed while displaying |

## Verification
The bench uses the default parameters: a 12-bit offset, 32-bit data, five interrupt bits, 7-bit palette index, and 11-bit column and row outputs. With 11-bit geometry, the largest results of both formulas (1024 columns and 1024 rows) can be reached without truncation. With five status bits, a mask write carrying set upper bits shows that those bits are dropped. The full 128-entry palette index range is also reachable, so both ends of that window are exercised.

// File: rtl/lcdc_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the LCD controller register file.
// Assumes a 32-bit control word layout; indices are offset divided by four.
package lcdc_pkg;

    typedef enum logic [1:0] {
        RGN_REG  = 2'd0,
        RGN_PAL  = 2'd1,
        RGN_ID   = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    // word indices inside the register region
    localparam logic [3:0] IX_TIM0   = 4'd0;
    localparam logic [3:0] IX_TIM1   = 4'd1;
    localparam logic [3:0] IX_TIM3   = 4'd3;
    localparam logic [3:0] IX_UPB    = 4'd4;
    localparam logic [3:0] IX_LOB    = 4'd5;
    localparam logic [3:0] IX_MASK   = 4'd6;
    localparam logic [3:0] IX_CTRL   = 4'd7;
    localparam logic [3:0] IX_RAW    = 4'd8;
    localparam logic [3:0] IX_MSKD   = 4'd9;
    localparam logic [3:0] IX_ICLR   = 4'd10;
    localparam logic [3:0] IX_CUR_UP = 4'd11;
    localparam logic [3:0] IX_CUR_LO = 4'd12;

    // control word bit positions
    localparam int CB_EN    = 0;
    localparam int CB_MODE  = 1;
    localparam int CB_RB    = 8;
    localparam int CB_BYTE  = 9;
    localparam int CB_PIX   = 10;
    localparam int CB_PWR   = 11;

    // identification byte for a given word of the top window
    function automatic logic [7:0] id_byte(input logic [2:0] sel);
        logic [7:0] b;
        case (sel)
            3'd0:    b = 8'h10;
            3'd1:    b = 8'h11;
            3'd2:    b = 8'h04;
            3'd3:    b = 8'h00;
            3'd4:    b = 8'h0D;
            3'd5:    b = 8'hF0;
            3'd6:    b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/lcdc_addr_decode.sv
`timescale 1ns/1ps
// Module: lcdc_addr_decode
// Splits a byte offset into a region (registers, palette, identification,
// unmapped) plus the sub-index each region needs. Purely combinational.
// Assumes word-aligned offsets; the two low address bits are not decoded.
module lcdc_addr_decode
    import lcdc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int PAL_IDX_W = 7,
    parameter logic [ADDR_W-1:0] PAL_BASE = 12'h200
) (
    input  logic [ADDR_W-1:0]    addr,
    output region_e              region,
    output logic [3:0]           reg_idx,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [2:0]           id_sel
);
    localparam int PAL_LSB = PAL_IDX_W + 2;

    logic [1:0] unused_low;
    assign unused_low = addr[1:0];

    assign reg_idx = addr[5:2];
    assign pal_idx = addr[PAL_LSB-1:2];
    assign id_sel  = addr[4:2];

    // classify the offset into one of the four regions
    always_comb begin
        region = RGN_NONE;
        if (addr[ADDR_W-1:6] == '0 && addr[5:2] <= IX_CUR_LO)
            region = RGN_REG;
        else if (addr[ADDR_W-1:PAL_LSB] == PAL_BASE[ADDR_W-1:PAL_LSB])
            region = RGN_PAL;
        else if (addr[ADDR_W-1:5] == '1)
            region = RGN_ID;
    end

endmodule

// File: rtl/lcdc_geometry.sv
`timescale 1ns/1ps
// Module: lcdc_geometry
// Holds panel columns and rows, recomputed whenever a timing word is
// written, and flags a size change while the display is on.
// Assumes at most one of t0_we/t1_we is high in a cycle.
module lcdc_geometry #(
    parameter int COL_W = 11,
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_now,
    input  logic             t0_we,
    input  logic             t1_we,
    input  logic [5:0]       col_field,
    input  logic [9:0]       row_field,
    output logic [COL_W-1:0] cols,
    output logic [ROW_W-1:0] rows,
    output logic             resize
);
    logic [COL_W-1:0] col_calc;
    logic [ROW_W-1:0] row_calc;

    // width is (field + 1) * 16, height is field + 1
    assign col_calc = COL_W'((32'(col_field) + 32'd1) << 4);
    assign row_calc = ROW_W'(32'(row_field) + 32'd1);

    // update geometry and raise a one-cycle resize on a change while on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cols   <= '0;
            rows   <= '0;
            resize <= 1'b0;
        end else begin
            resize <= 1'b0;
            if (t0_we) begin
                cols <= col_calc;
                if (en_now && col_calc != cols) resize <= 1'b1;
            end
            if (t1_we) begin
                rows <= row_calc;
                if (en_now && row_calc != rows) resize <= 1'b1;
            end
        end
    end

    AST_COLS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        t0_we |=> cols == COL_W'((({24'd0, $past(col_field), 2'b00} + 32'd4) * 32'd4))); // R3
    AST_ROWS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        t1_we |=> rows == ROW_W'({22'd0, $past(row_field)} + 32'd1)); // R4
    AST_RESIZE_WHEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
        resize |-> $past(en_now)); // R12
    AST_RESIZE_NO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!t0_we && !t1_we) |=> !resize); // R12

endmodule

// File: rtl/lcdc_irq.sv
`timescale 1ns/1ps
// Module: lcdc_irq
// Sticky interrupt status with an enable mask and write-one-to-clear.
// Assumes set pulses come from the same clock domain; set beats clear.
module lcdc_irq #(
    parameter int IRQ_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [IRQ_W-1:0] wdata,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] masked
);
    logic [IRQ_W-1:0] clr_bits;

    assign clr_bits = clr_we ? wdata : '0;
    assign masked   = raw & mask;

    // keep mask and status; new sets are ORed in after clearing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
            raw  <= '0;
        end else begin
            if (mask_we) mask <= wdata;
            raw <= (raw & ~clr_bits) | set;
        end
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((raw & $past(set)) == $past(set))); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((raw & $past(wdata) & ~$past(set)) == '0)); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_we && set == '0) |=> $stable(raw)); // R6

endmodule

// File: rtl/lcdc_regfile.sv
`timescale 1ns/1ps
// Module: lcdc_regfile (top)
// Bus-facing register bank of a colour LCD controller: timing words, frame
// bases, interrupt mask/status/clear, control word, palette forwarding and
// an identification window. Read data and error are registered one cycle.
// Assumes one access per cycle and word-aligned offsets.
module lcdc_regfile
    import lcdc_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int IRQ_W     = 5,
    parameter int PAL_IDX_W = 7,
    parameter int COL_W     = 11,
    parameter int ROW_W     = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_err,
    input  logic [IRQ_W-1:0]     irq_set,
    output logic                 pal_we,
    output logic [PAL_IDX_W-1:0] pal_idx,
    output logic [DATA_W-1:0]    pal_wdata,
    output logic [COL_W-1:0]     panel_cols,
    output logic [ROW_W-1:0]     panel_rows,
    output logic [2:0]           pix_mode,
    output logic                 disp_on,
    output logic                 swap_rb,
    output logic                 byte_be,
    output logic                 pixel_be,
    output logic [DATA_W-1:0]    upper_base,
    output logic [DATA_W-1:0]    lower_base,
    output logic                 resize_pulse
);
    localparam int TIM_N = 4;

    region_e              rgn;
    logic [3:0]           widx;
    logic [PAL_IDX_W-1:0] pidx;
    logic [2:0]           isel;

    lcdc_addr_decode #(
        .ADDR_W    (ADDR_W),
        .PAL_IDX_W (PAL_IDX_W)
    ) u_dec (
        .addr    (bus_addr),
        .region  (rgn),
        .reg_idx (widx),
        .pal_idx (pidx),
        .id_sel  (isel)
    );

    logic wr_go, rd_go, reg_wr_ok, pal_wr_ok, rd_ok, acc_bad;
    assign wr_go     = bus_sel & bus_wr;
    assign rd_go     = bus_sel & ~bus_wr;
    assign reg_wr_ok = wr_go && rgn == RGN_REG && (widx <= IX_CTRL || widx == IX_ICLR);
    assign pal_wr_ok = wr_go && rgn == RGN_PAL;
    assign rd_ok     = rd_go && (rgn == RGN_PAL || rgn == RGN_ID ||
                                 (rgn == RGN_REG && widx != IX_ICLR));
    assign acc_bad   = bus_sel && !(rd_ok || reg_wr_ok || pal_wr_ok);

    // one write strobe per timing word
    logic [TIM_N-1:0] tim_we;
    for (genvar g = 0; g < TIM_N; g++) begin : g_tim_we
        assign tim_we[g] = reg_wr_ok && widx == 4'(g);
    end

    logic [DATA_W-1:0] tim_q [TIM_N];
    logic [DATA_W-1:0] ctl_q;

    // store timing words, frame bases and control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TIM_N; i++) tim_q[i] <= '0;
            upper_base <= '0;
            lower_base <= '0;
            ctl_q      <= '0;
        end else begin
            for (int i = 0; i < TIM_N; i++)
                if (tim_we[i]) tim_q[i] <= bus_wdata;
            if (reg_wr_ok && widx == IX_UPB)  upper_base <= bus_wdata;
            if (reg_wr_ok && widx == IX_LOB)  lower_base <= bus_wdata;
            if (reg_wr_ok && widx == IX_CTRL) ctl_q      <= bus_wdata;
        end
    end

    // control word decode for the pixel pipeline
    assign disp_on  = ctl_q[CB_EN] & ctl_q[CB_PWR];
    assign pix_mode = ctl_q[CB_MODE+2:CB_MODE];
    assign swap_rb  = ctl_q[CB_RB];
    assign byte_be  = ctl_q[CB_BYTE];
    assign pixel_be = ctl_q[CB_PIX];

    logic [IRQ_W-1:0] irq_mask, irq_raw, irq_mskd;

    lcdc_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (irq_set),
        .mask_we (reg_wr_ok && widx == IX_MASK),
        .clr_we  (reg_wr_ok && widx == IX_ICLR),
        .wdata   (bus_wdata[IRQ_W-1:0]),
        .mask    (irq_mask),
        .raw     (irq_raw),
        .masked  (irq_mskd)
    );

    lcdc_geometry #(.COL_W(COL_W), .ROW_W(ROW_W)) u_geo (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_now    (disp_on),
        .t0_we     (tim_we[IX_TIM0]),
        .t1_we     (tim_we[IX_TIM1]),
        .col_field (bus_wdata[7:2]),
        .row_field (bus_wdata[9:0]),
        .cols      (panel_cols),
        .rows      (panel_rows),
        .resize    (resize_pulse)
    );

    // read multiplexer over registers and the identification window
    logic [DATA_W-1:0] rd_val;
    always_comb begin
        rd_val = '0;
        if (rgn == RGN_ID) begin
            rd_val = {{(DATA_W-8){1'b0}}, id_byte(isel)};
        end else if (rgn == RGN_REG) begin
            case (widx)
                IX_UPB, IX_CUR_UP: rd_val = upper_base;
                IX_LOB, IX_CUR_LO: rd_val = lower_base;
                IX_MASK:           rd_val = DATA_W'(irq_mask);
                IX_CTRL:           rd_val = ctl_q;
                IX_RAW:            rd_val = DATA_W'(irq_raw);
                IX_MSKD:           rd_val = DATA_W'(irq_mskd);
                default:           if (widx <= IX_TIM3) rd_val = tim_q[widx[1:0]];
            endcase
        end
    end

    // register the bus response one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_ok ? rd_val : '0;
            bus_err   <= acc_bad;
        end
    end

    // forward palette window writes as a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pal_we    <= 1'b0;
            pal_idx   <= '0;
            pal_wdata <= '0;
        end else begin
            pal_we <= pal_wr_ok;
            if (pal_wr_ok) begin
                pal_idx   <= pidx;
                pal_wdata <= bus_wdata;
            end
        end
    end

    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == '0); // R11
    AST_ERR_NO_PAL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> !pal_we); // R11
    AST_ENABLE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_ok && widx == IX_CTRL) |=>
            disp_on == ($past(bus_wdata[CB_EN]) && $past(bus_wdata[CB_PWR]))); // R5
    AST_PAL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr[ADDR_W-1:PAL_IDX_W+2] == 3'b001) |=>
            (pal_we && pal_idx == $past(bus_addr[PAL_IDX_W+1:2]))); // R9
    AST_PAL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pal_we |-> $past(bus_sel && bus_wr)); // R9

endmodule

// File: tb/sim_lcdc_regfile.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers push expected observations with their due
// cycle; a negedge monitor pops and compares them.
module sim_lcdc_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [4:0]  irq_set = '0;
    logic        pal_we;
    logic [6:0]  pal_idx;
    logic [31:0] pal_wdata;
    logic [10:0] panel_cols, panel_rows;
    logic [2:0]  pix_mode;
    logic        disp_on, swap_rb, byte_be, pixel_be, resize_pulse;
    logic [31:0] upper_base, lower_base;

    lcdc_regfile u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .irq_set(irq_set), .pal_we(pal_we),
        .pal_idx(pal_idx), .pal_wdata(pal_wdata), .panel_cols(panel_cols),
        .panel_rows(panel_rows), .pix_mode(pix_mode), .disp_on(disp_on),
        .swap_rb(swap_rb), .byte_be(byte_be), .pixel_be(pixel_be),
        .upper_base(upper_base), .lower_base(lower_base),
        .resize_pulse(resize_pulse)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef enum {OB_RDATA, OB_ERR, OB_COLS, OB_ROWS, OB_EN, OB_MODE,
                  OB_FLAGS, OB_RESIZE, OB_PALWE, OB_PALIDX, OB_PALDAT} obs_e;
    typedef struct {
        int          due;
        obs_e        what;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] observe(input obs_e w);
        case (w)
            OB_RDATA:  return bus_rdata;
            OB_ERR:    return {31'd0, bus_err};
            OB_COLS:   return {21'd0, panel_cols};
            OB_ROWS:   return {21'd0, panel_rows};
            OB_EN:     return {31'd0, disp_on};
            OB_MODE:   return {29'd0, pix_mode};
            OB_FLAGS:  return {29'd0, swap_rb, byte_be, pixel_be};
            OB_RESIZE: return {31'd0, resize_pulse};
            OB_PALWE:  return {31'd0, pal_we};
            OB_PALIDX: return {25'd0, pal_idx};
            default:   return pal_wdata;
        endcase
    endfunction

    // monitor: compare every item that is due at this falling edge
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t it;
            logic [31:0] got;
            it = sbq.pop_front();
            got = observe(it.what);
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic expect_obs(input obs_e w, input logic [31:0] e, input string tag, input int lag);
        item_t it;
        it.due = cyc + lag; it.what = w; it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic drive(input logic s, input logic w, input logic [11:0] a,
                         input logic [31:0] d, input logic [4:0] irq);
        @(posedge clk); #1;
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; irq_set = irq;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, 12'h0, 32'h0, 5'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic e, input string tag);
        drive(1'b1, 1'b1, a, d, 5'h0);
        expect_obs(OB_ERR, {31'd0, e}, tag, 1);
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input logic ee, input string tag);
        drive(1'b1, 1'b0, a, 32'h0, 5'h0);
        expect_obs(OB_RDATA, e, tag, 1);
        expect_obs(OB_ERR, {31'd0, ee}, tag, 1);
    endtask

    function automatic logic [31:0] ref_cols(input logic [31:0] v);
        return ((v & 32'hFC) + 32'd4) * 32'd4;
    endfunction
    function automatic logic [31:0] ref_rows(input logic [31:0] v);
        return (v & 32'h3FF) + 32'd1;
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin : stim
        logic [7:0] idv [8];
        idv = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        repeat (3) idle();
        @(posedge clk); #1; rst_n = 1'b1;

        // R1 reset state
        expect_obs(OB_COLS, 0, "R1 cols", 1);
        expect_obs(OB_ROWS, 0, "R1 rows", 1);
        expect_obs(OB_EN, 0, "R1 disp_on", 1);
        expect_obs(OB_FLAGS, 0, "R1 flags", 1);
        expect_obs(OB_PALWE, 0, "R1 pal_we", 1);
        for (int i = 0; i < 13; i++)
            if (i != 10) rd(12'(i * 4), 32'h0, 1'b0, "R1 reset read");

        // R2 read/write words, R3/R4 geometry while display off
        wr(12'h000, 32'hFFFF_FFFF, 1'b0, "R3 t0 write");
        expect_obs(OB_COLS, ref_cols(32'hFFFF_FFFF), "R3 cols max", 1);
        expect_obs(OB_RESIZE, 0, "R12 no resize when off", 1);
        wr(12'h004, 32'h0001_2345, 1'b0, "R4 t1 write");
        expect_obs(OB_ROWS, ref_rows(32'h0001_2345), "R4 rows", 1);
        wr(12'h008, 32'hA5A5_0001, 1'b0, "R2 t2");
        wr(12'h00C, 32'h5A5A_0002, 1'b0, "R2 t3");
        wr(12'h010, 32'h8000_1000, 1'b0, "R2 ub");
        wr(12'h014, 32'h8004_0000, 1'b0, "R2 lb");
        rd(12'h000, 32'hFFFF_FFFF, 1'b0, "R2 t0 read");
        rd(12'h004, 32'h0001_2345, 1'b0, "R2 t1 read");
        rd(12'h008, 32'hA5A5_0001, 1'b0, "R2 t2 read");
        rd(12'h00C, 32'h5A5A_0002, 1'b0, "R2 t3 read");
        rd(12'h010, 32'h8000_1000, 1'b0, "R2 ub read");
        rd(12'h014, 32'h8004_0000, 1'b0, "R2 lb read");
        rd(12'h02C, 32'h8000_1000, 1'b0, "R8 upper current");
        rd(12'h030, 32'h8004_0000, 1'b0, "R8 lower current");
        wr(12'h004, 32'h0000_03FF, 1'b0, "R4 t1 max");
        expect_obs(OB_ROWS, ref_rows(32'h3FF), "R4 rows max", 1);
        wr(12'h000, 32'h0000_0003, 1'b0, "R3 t0 min");
        expect_obs(OB_COLS, ref_cols(32'h3), "R3 cols min", 1);

        // R5 control decode
        wr(12'h01C, 32'h0000_0001, 1'b0, "R5 en only");
        expect_obs(OB_EN, 0, "R5 enable without power", 1);
        wr(12'h01C, 32'h0000_0800, 1'b0, "R5 pwr only");
        expect_obs(OB_EN, 0, "R5 power without enable", 1);
        wr(12'h01C, 32'h0000_080B, 1'b0, "R5 both");
        expect_obs(OB_EN, 1, "R5 enable and power", 1);
        expect_obs(OB_MODE, 5, "R5 mode bits", 1);
        expect_obs(OB_FLAGS, 0, "R5 flags clear", 1);
        wr(12'h01C, 32'h0000_0F01, 1'b0, "R5 flags");
        expect_obs(OB_FLAGS, 32'h7, "R5 order flags", 1);
        expect_obs(OB_EN, 1, "R5 still on", 1);
        rd(12'h01C, 32'h0000_0F01, 1'b0, "R2 ctrl read");

        // R12 resize pulses while on
        wr(12'h000, 32'h0000_0010, 1'b0, "R12 t0 change");
        expect_obs(OB_RESIZE, 1, "R12 resize on col change", 1);
        expect_obs(OB_COLS, ref_cols(32'h10), "R3 cols new", 1);
        idle();
        expect_obs(OB_RESIZE, 0, "R12 single cycle", 1);
        wr(12'h000, 32'h0000_0013, 1'b0, "R12 same cols");
        expect_obs(OB_RESIZE, 0, "R12 no resize same size", 1);
        wr(12'h004, 32'h0000_0100, 1'b0, "R12 t1 change");
        expect_obs(OB_RESIZE, 1, "R12 resize on row change", 1);

        // R6/R7 interrupts
        wr(12'h018, 32'hFFFF_FFE5, 1'b0, "R6 mask");
        rd(12'h018, 32'h0000_0005, 1'b0, "R6 mask width");
        drive(1'b0, 1'b0, 12'h0, 32'h0, 5'h1F);
        idle();
        rd(12'h020, 32'h1F, 1'b0, "R6 raw after set");
        rd(12'h024, 32'h05, 1'b0, "R6 masked");
        wr(12'h028, 32'h0000_0003, 1'b0, "R7 clear write");
        rd(12'h020, 32'h1C, 1'b0, "R7 raw after clear");
        drive(1'b1, 1'b1, 12'h028, 32'h0000_0014, 5'h04);
        rd(12'h020, 32'h0C, 1'b0, "R7 set wins over clear");
        rd(12'h024, 32'h04, 1'b0, "R6 masked after clear");

        // R9 palette forwarding
        wr(12'h200, 32'hCAFE_0001, 1'b0, "R9 pal low");
        expect_obs(OB_PALWE, 1, "R9 pal_we", 1);
        expect_obs(OB_PALIDX, 0, "R9 pal idx low", 1);
        expect_obs(OB_PALDAT, 32'hCAFE_0001, "R9 pal data", 1);
        wr(12'h3FC, 32'h1234_5678, 1'b0, "R9 pal high");
        expect_obs(OB_PALIDX, 127, "R9 pal idx high", 1);
        rd(12'h204, 32'h0, 1'b0, "R9 pal read zero");
        expect_obs(OB_PALWE, 0, "R9 no pal_we on read", 1);

        // R10 identification bytes
        for (int i = 0; i < 8; i++)
            rd(12'hFE0 + 12'(i * 4), {24'd0, idv[i]}, 1'b0, "R10 id byte");

        // R11 rejected accesses
        rd(12'h034, 32'h0, 1'b1, "R11 unmapped read");
        wr(12'h400, 32'hFFFF_FFFF, 1'b1, "R11 unmapped write");
        expect_obs(OB_PALWE, 0, "R11 no pal_we", 1);
        rd(12'h028, 32'h0, 1'b1, "R11 read of clear index");
        wr(12'h020, 32'h0000_0000, 1'b1, "R11 write raw index");
        rd(12'h020, 32'h0C, 1'b0, "R11 raw unchanged");
        wr(12'h02C, 32'h0000_0000, 1'b1, "R11 write current index");
        rd(12'h010, 32'h8000_1000, 1'b0, "R11 base unchanged");
        wr(12'hFE0, 32'h0000_0000, 1'b1, "R11 write id");
        rd(12'hFE0, 32'h10, 1'b0, "R11 id unchanged");
        wr(12'hF00, 32'h0000_0000, 1'b1, "R11 write gap");
        expect_obs(OB_COLS, ref_cols(32'h13), "R11 cols unchanged", 1);
        expect_obs(OB_FLAGS, 32'h7, "R11 ctrl unchanged", 1);
        idle();
        repeat (3) idle();

        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R11 scoreboard: actual %0d left expected 0", sbq.size());
        end
        done = 1;
        summary();
    end

endmodule